// File: doc/BRIEF.md
# Paired-Slot Shared Bus Arbiter

This block decides, once per clock, which of eight cores may use a shared memory bus. Every cycle belongs to one core in a fixed rotation: the slot owner. Cores are tied in pairs whose indices differ by four. Each core has a two-bit sharing mode. The mode lets a core do one of four things: keep its own slot as usual, hand its slot to its partner, take its partner's idle slots ahead of everyone else, or accept only cycles that no other core wants.

Each cycle the arbiter looks at the per-core request lines, the mode fields and the current owner, and resolves the claims in a fixed priority order. It then registers a one-hot grant together with the index of the slot that was decided.

A greedy core whose partner gives its slot away is served twice per rotation, four cycles apart. This is the way to give one core of a pair extra bandwidth that it can count on.

Top module: `pair_slot_arbiter`

## Requirements
- R1: While `rst` is high, `grant` is all zeros and `slot_owner` is 0. The first clock edge after release decides slot 0.
- R2: Each clock edge decides one slot. The slots are decided in the order 0,1,…,7 and then wrap to 0. After the edge that decides slot s, `slot_owner` shows s and `grant` shows the result for s.
- R3: At most one `grant` bit is high. If no core is eligible for a slot, `grant` is all zeros.
- R4: A requesting owner in mode 00 (normal) or 10 (greedy) always receives its own slot.
- R5: If the owner does not win its slot, the partner (core index XOR 4) receives it when the partner requests and is in mode 10. The partner takes priority over all other cores.
- R6: If the owner is in mode 01 (giving), its requesting partner receives the slot, whatever mode the partner is in.
- R7: If neither the owner nor the partner takes the slot, it goes to the first requesting core in mode 00, 01 or 10. The search starts at the owner index plus one, moves upward and wraps past 7. The owner itself is excluded from this search.
- R8: A core in mode 11 (leftover) receives a slot only when no core in another mode claims it. This includes the core's own slot. Among mode-11 cores, the search starts at the owner index plus one, moves upward and wraps, and ends at the owner.
- R9: A giving owner receives its own slot only when no other core claims it.
- R10: A greedy core whose partner is giving, with both requesting, is granted at both slot s and slot s XOR 4 in every rotation.
- R11: The mode of core i is read from `mode[2i+1:2i]`. The encodings are 00 normal, 01 giving, 10 greedy and 11 leftover.
- R12: Modes and requests are sampled only at the edge that decides a slot. A change made during a cycle leaves the current `grant` unchanged and affects only the slots decided afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 8 | Per-core bus request |
| mode | input | 16 | Per-core two-bit sharing mode, core i at bits 2i+1:2i |
| grant | output | 8 | Registered one-hot grant for the slot just decided |
| slot_owner | output | 3 | Registered index of the slot just decided |

## Verification
Every result arrives exactly one edge after the inputs that produce it are sampled. The grant and owner for slot s appear after the edge that decides s, and the outputs hold for that whole cycle. The bench drives inputs on the falling edge and keeps its own slot counter, which starts at 0 after reset. It then waits for one rising edge and compares both outputs on the next falling edge against a priority model derived from the requirements. For the mode-change case, the bench alters `mode` in the middle of a cycle and checks a few nanoseconds later that the grant already shown has not moved. It then checks that the next decided slot follows the new mode.

// File: rtl/share_arb_pkg.sv
package share_arb_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL   = 2'b00,
    MODE_GIVE     = 2'b01,
    MODE_GREEDY   = 2'b10,
    MODE_LEFTOVER = 2'b11
  } share_mode_e;
endpackage

// File: rtl/slot_ring.sv
module slot_ring #(
  parameter int N = 8,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [IW-1:0] cur
);
  logic [IW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_q + IW'(1);
  end

  assign cur = cnt_q;
endmodule

// File: rtl/slot_claims.sv
module slot_claims import share_arb_pkg::*; #(
  parameter int N = 8,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]   req,
  input  logic [2*N-1:0] mode,
  input  logic [IW-1:0]  owner,
  output logic [IW-1:0]  twin,
  output logic           own_win,
  output logic           twin_win,
  output logic           giver_win,
  output logic [N-1:0]   open_mask,
  output logic [N-1:0]   spare_mask
);
  localparam logic [IW-1:0] HALF = IW'(N / 2);

  share_mode_e md [N];
  share_mode_e own_md, twin_md;

  for (genvar g = 0; g < N; g++) begin : g_core
    assign md[g]         = share_mode_e'(mode[2*g +: 2]);
    assign open_mask[g]  = req[g] && (md[g] != MODE_LEFTOVER) && (IW'(g) != owner);
    assign spare_mask[g] = req[g] && (md[g] == MODE_LEFTOVER);
  end

  assign twin    = owner ^ HALF;
  assign own_md  = md[owner];
  assign twin_md = md[twin];

  assign own_win   = req[owner] && (own_md == MODE_NORMAL || own_md == MODE_GREEDY);
  assign twin_win  = req[twin] && (twin_md == MODE_GREEDY || own_md == MODE_GIVE);
  assign giver_win = req[owner] && (own_md == MODE_GIVE);
endmodule

// File: rtl/rr_pick.sv
module rr_pick #(
  parameter int N = 8,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  mask,
  input  logic [IW-1:0] start,
  output logic          hit,
  output logic [IW-1:0] idx
);
  always_comb begin
    logic [IW-1:0] pos;
    hit = 1'b0;
    idx = '0;
    for (int k = N - 1; k >= 0; k--) begin
      pos = start + IW'(k);
      if (mask[pos]) begin
        hit = 1'b1;
        idx = pos;
      end
    end
  end
endmodule

// File: rtl/pair_slot_arbiter.sv
module pair_slot_arbiter import share_arb_pkg::*; #(
  parameter int N = 8,
  localparam int IW = $clog2(N)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [N-1:0]   req,
  input  logic [2*N-1:0] mode,
  output logic [N-1:0]   grant,
  output logic [IW-1:0]  slot_owner
);
  logic [IW-1:0] cur, twin, start, open_idx, spare_idx, win_idx;
  logic          own_win, twin_win, giver_win, open_hit, spare_hit, win_hit;
  logic [N-1:0]  open_mask, spare_mask, nxt_grant;

  slot_ring #(.N(N)) u_ring (.clk(clk), .rst(rst), .cur(cur));

  slot_claims #(.N(N)) u_claims (
    .req(req), .mode(mode), .owner(cur), .twin(twin),
    .own_win(own_win), .twin_win(twin_win), .giver_win(giver_win),
    .open_mask(open_mask), .spare_mask(spare_mask)
  );

  assign start = cur + IW'(1);

  rr_pick #(.N(N)) u_open  (.mask(open_mask),  .start(start), .hit(open_hit),  .idx(open_idx));
  rr_pick #(.N(N)) u_spare (.mask(spare_mask), .start(start), .hit(spare_hit), .idx(spare_idx));

  always_comb begin
    win_hit = 1'b1;
    if (own_win)        win_idx = cur;
    else if (twin_win)  win_idx = twin;
    else if (open_hit)  win_idx = open_idx;
    else if (spare_hit) win_idx = spare_idx;
    else if (giver_win) win_idx = cur;
    else begin
      win_hit = 1'b0;
      win_idx = '0;
    end
    nxt_grant = '0;
    if (win_hit) nxt_grant[win_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grant      <= '0;
      slot_owner <= '0;
    end else begin
      grant      <= nxt_grant;
      slot_owner <= cur;
    end
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant)); // R3
  AST_IDLE_NO_GRANT: assert property (@(posedge clk) disable iff (rst)
    (req == '0) |=> (grant == '0)); // R3
  AST_OWNER_KEEPS: assert property (@(posedge clk) disable iff (rst)
    own_win |=> grant[$past(cur)]); // R4
  AST_GREEDY_TWIN: assert property (@(posedge clk) disable iff (rst)
    (!own_win && req[twin] && mode[2*twin +: 2] == 2'b10) |=> grant[$past(twin)]); // R5
  AST_GIVER_LAST: assert property (@(posedge clk) disable iff (rst)
    (giver_win && !twin_win && !open_hit && !spare_hit) |=> grant[$past(cur)]); // R9
  AST_SLOT_WRAP: assert property (@(posedge clk) disable iff (rst)
    (slot_owner == IW'(N - 1)) |=> (slot_owner == '0)); // R2
endmodule

// File: tb/sim_pair_slot_arbiter.sv
module sim_pair_slot_arbiter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  req = '0;
  logic [15:0] mode = '0;
  logic [7:0]  grant;
  logic [2:0]  slot_owner;

  int checks = 0;
  int fails  = 0;
  int sl     = 0;

  always #10 clk = ~clk;

  pair_slot_arbiter u0 (.clk(clk), .rst(rst), .req(req), .mode(mode),
                        .grant(grant), .slot_owner(slot_owner));

  function automatic logic [15:0] md(input int core, input logic [1:0] m);
    return 16'(m) << (2 * core);
  endfunction

  // Priority model written from the requirements
  function automatic logic [7:0] model(input logic [7:0] r, input logic [15:0] m, input int s);
    int t = s ^ 4;
    logic [1:0] mo = m[2*s +: 2];
    logic [1:0] mt = m[2*t +: 2];
    if (r[s] && mo != 2'b01 && mo != 2'b11) return 8'(1) << s;
    if (r[t] && (mt == 2'b10 || mo == 2'b01)) return 8'(1) << t;
    for (int k = 1; k < 8; k++) begin
      int c = (s + k) % 8;
      if (r[c] && m[2*c +: 2] != 2'b11) return 8'(1) << c;
    end
    for (int k = 1; k <= 8; k++) begin
      int c = (s + k) % 8;
      if (r[c] && m[2*c +: 2] == 2'b11) return 8'(1) << c;
    end
    if (r[s] && mo == 2'b01) return 8'(1) << s;
    return 8'h00;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  // Drive at falling edge, one decision edge, compare at next falling edge
  task automatic tick(input logic [7:0] r, input logic [15:0] m, input string tag);
    logic [7:0] exp;
    req  = r;
    mode = m;
    exp  = model(r, m, sl);
    @(posedge clk);
    @(negedge clk);
    chk({tag, " grant"}, 32'(grant), 32'(exp));
    chk("R2 slot_owner", 32'(slot_owner), 32'(sl));
    sl = (sl + 1) % 8;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    req = 8'hFF;
    repeat (3) @(negedge clk);
    chk("R1 grant in reset", 32'(grant), 32'h0);
    chk("R1 owner in reset", 32'(slot_owner), 32'h0);
    rst = 1'b0;
    sl  = 0;
  endtask

  task automatic t_rotate();
    for (int i = 0; i < 9; i++) tick(8'h00, 16'h0000, "R3 idle");
  endtask

  task automatic t_all_normal();
    for (int i = 0; i < 8; i++) begin
      tick(8'hFF, 16'h0000, "R4 all normal");
      chk("R4 owner wins", 32'(grant), 32'(8'(1) << ((sl + 7) % 8)));
    end
  endtask

  task automatic t_greedy();
    for (int i = 0; i < 8; i++) tick(8'h12, md(4, 2'b10), "R5 greedy twin");
  endtask

  task automatic t_give_pair();
    int hits = 0;
    while (sl != 0) tick(8'h00, 16'h0000, "R3 align");
    for (int i = 0; i < 8; i++) begin
      tick(8'h11, md(0, 2'b01) | md(4, 2'b10), "R10 give+greedy");
      if (i == 0 || i == 4) begin
        chk("R10 twin slot", 32'(grant), 32'h10);
        hits++;
      end
    end
    chk("R10 two fixed slots", 32'(hits), 32'd2);
    for (int i = 0; i < 8; i++) tick(8'h11, md(0, 2'b01), "R6 give to normal twin");
  endtask

  task automatic t_scan();
    for (int i = 0; i < 8; i++) tick(8'h22, 16'h0000, "R7 upward scan");
    for (int i = 0; i < 8; i++) tick(8'h83, md(7, 2'b01), "R7 scan with giver");
  endtask

  task automatic t_leftover();
    for (int i = 0; i < 8; i++) tick(8'h08, md(3, 2'b11), "R8 leftover alone");
    for (int i = 0; i < 8; i++) tick(8'h28, md(3, 2'b11), "R8 leftover yields");
    for (int i = 0; i < 8; i++) tick(8'h0C, md(3, 2'b11) | md(2, 2'b11), "R8 leftover order");
  endtask

  task automatic t_giver_last();
    for (int i = 0; i < 8; i++) tick(8'h04, md(2, 2'b01), "R9 giver alone");
    for (int i = 0; i < 8; i++) tick(8'h0C, md(2, 2'b01) | md(3, 2'b11), "R9 giver vs leftover");
    for (int i = 0; i < 8; i++) tick(8'h44, md(2, 2'b01), "R9 giver vs twin");
  endtask

  task automatic t_mode_field();
    for (int c = 0; c < 8; c++) tick(8'(1) << c | 8'(1) << (c ^ 4), md(c, 2'b01), "R11 field position");
  endtask

  task automatic t_mode_change();
    logic [7:0] held;
    tick(8'hFF, 16'h0000, "R12 before change");
    held = grant;
    mode = md(sl, 2'b11) | md((sl + 7) % 8, 2'b11);
    #3;
    chk("R12 grant held", 32'(grant), 32'(held));
    tick(8'hFF, md(sl, 2'b11), "R12 new mode applied");
  endtask

  task automatic t_sweep();
    logic [31:0] lf = 32'h1ACE_5EED;
    for (int i = 0; i < 240; i++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      tick(lf[7:0] & lf[31:24], lf[23:8], "R7 sweep");
    end
  endtask

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_rotate();
    t_all_normal();
    t_greedy();
    t_give_pair();
    t_scan();
    t_leftover();
    t_giver_last();
    t_mode_field();
    t_mode_change();
    t_sweep();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule